// File: doc/BRIEF.md
# Event-Gated Performance Counter Unit

The unit counts processor events over a measurement window. Each of its counter channels is assigned one event source, chosen from six: clock cycles, taken branches, executed instructions, interrupts, cache misses and stalls. All channels count at the same time. A channel holds a counter and a sticky overflow flag. Once the flag is set, the channel's result is read back as not valid.

The window can follow the user program's run status. It can also be bounded by two break-condition events. Either condition may open the window, and the other one closes it. While a condition-bounded window is selected, the unit masks both conditions from causing a break. Counting pauses while the CPU clock is halted in sleep.

A small write port sets the window mode and the event assigned to each channel. A write to the initialize address clears every result. A channel select returns that channel's count together with a valid flag.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every channel reads 0 with rd_valid_o high. The window mode is run-gated (code 0), every channel is unassigned (code 0), cfg_err_o is low and brk_mask_o is 2'b00.
- R2: Write address 0, bits [1:0], sets the mode: 0 is run-gated, 1 is condition 1 to condition 2, 2 is condition 2 to condition 1, and 3 is off. Write address k+1, bits [2:0], sets the event of channel k. The event codes are 1 cycle, 2 branch, 3 instruction, 4 interrupt, 5 cache miss and 6 stall, matching evt_i bits 0 to 5. Code 0 or 7 means unassigned. In run-gated mode, a channel adds its event in every cycle where run_i is high, and only in those cycles.
- R3: A channel assigned the branch event adds 2 for each branch pulse.
- R4: In mode 1, the cycle in which cond1_i opens the window is counted. Every later cycle up to and including the cycle in which cond2_i closes it is also counted. A cond2_i with no open window has no effect. After the window closes, it does not reopen until the mode is written again or the unit is initialized.
- R5: Mode 2 works in the same way, with cond2_i opening the window and cond1_i closing it.
- R6: No channel changes in a cycle where sleep_i is high.
- R7: An increment that would pass the counter's maximum value sets the channel's overflow flag. The count keeps its value from before that increment, and rd_valid_o reads low for that channel. Further events leave the count unchanged until the unit is initialized.
- R8: A write to address 5 (the initialize command) clears every count, every overflow flag and the window state. An event in the same cycle is not counted.
- R9: brk_mask_o is 2'b11 in modes 1 and 2, and 2'b00 otherwise.
- R10: cfg_err_o is high while mode 1 or mode 2 is selected and no channel has an event assigned.
- R11: The channels count their own events independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Event pulses; bit n is event code n+1 |
| cond1_i | input | 1 | Break condition 1 satisfied |
| cond2_i | input | 1 | Break condition 2 satisfied |
| run_i | input | 1 | User program running |
| sleep_i | input | 1 | CPU clock halted in sleep |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_ch_i | input | 2 | Channel selected for readback |
| rd_cnt_o | output | CNT_W | Count of the selected channel |
| rd_valid_o | output | 1 | Selected channel has not overflowed |
| cfg_err_o | output | 1 | Gated mode with no channel assigned |
| win_open_o | output | 1 | Window is counting this cycle |
| brk_mask_o | output | 2 | Conditions 1 and 2 masked from break |

## Verification
Three functions can coincide with an event in a single cycle: the window opening, the window closing, and the initialize command. The bench provokes each case by raising the bounding condition, or issuing the clear write, in the same cycle as a counted event pulse. The expected counts include the pulse on both window boundaries and exclude it when it coincides with the clear. The overflow boundary is reached with a reduced counter width. Branch steps of 2 then land one step short of the limit, and the next step crosses it.

// File: rtl/perf_pkg.sv
package perf_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_C1C2 = 2'd1,
    MODE_C2C1 = 2'd2,
    MODE_OFF  = 2'd3
  } win_mode_e;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] EV_NONE   = 3'd0;
  localparam logic [SEL_W-1:0] EV_BRANCH = 3'd2;
endpackage

// File: rtl/perf_window.sv
module perf_window
  import perf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  win_mode_e mode_i,
  input  logic      rearm_i,
  input  logic      cond1_i,
  input  logic      cond2_i,
  input  logic      run_i,
  output logic      open_o
);
  logic active_q, done_q;
  logic gated, start, stop;

  assign gated = (mode_i == MODE_C1C2) || (mode_i == MODE_C2C1);
  assign start = (mode_i == MODE_C1C2) ? cond1_i : cond2_i;
  assign stop  = (mode_i == MODE_C1C2) ? cond2_i : cond1_i;

  always_comb begin
    if (mode_i == MODE_RUN)      open_o = run_i;
    else if (!gated)             open_o = 1'b0;
    else if (active_q)           open_o = 1'b1;
    else                         open_o = !done_q && start;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (rearm_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (gated) begin
      if (!active_q && !done_q && start) begin
        active_q <= 1'b1;
      end else if (active_q && stop) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  // R4: a closed window stays closed until rearmed
  a_r4_single_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !rearm_i) |=> !active_q);
endmodule

// File: rtl/perf_chan.sv
module perf_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [1:0]       step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(step_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en_i && !ovf_q && step_i != 2'd0) begin
      if (sum[CNT_W]) ovf_q <= 1'b1;
      else            cnt_q <= sum[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  a_r7_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> $stable(cnt_q));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !ovf_q));
  a_r3_step_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(2)));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perf_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_EVT = 6,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               cond1_i,
  input  logic               cond2_i,
  input  logic               run_i,
  input  logic               sleep_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [$clog2(NUM_CH)-1:0] rd_ch_i,
  output logic [CNT_W-1:0]   rd_cnt_o,
  output logic               rd_valid_o,
  output logic               cfg_err_o,
  output logic               win_open_o,
  output logic [1:0]         brk_mask_o
);
  localparam logic [ADDR_W-1:0] ADDR_MODE = '0;
  localparam logic [ADDR_W-1:0] ADDR_INIT = ADDR_W'(NUM_CH + 1);

  win_mode_e        mode_q;
  logic [SEL_W-1:0] sel_q [NUM_CH];
  logic [CNT_W-1:0] cnt   [NUM_CH];
  logic [NUM_CH-1:0] ovf;
  logic [NUM_CH-1:0] assigned;
  logic clr_cmd, mode_wr, cnt_en, gated;

  assign clr_cmd = wr_en_i && (wr_addr_i == ADDR_INIT);
  assign mode_wr = wr_en_i && (wr_addr_i == ADDR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else if (mode_wr) mode_q <= win_mode_e'(wr_data_i[1:0]);
  end

  perf_window u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q),
    .rearm_i (clr_cmd || mode_wr),
    .cond1_i (cond1_i),
    .cond2_i (cond2_i),
    .run_i   (run_i),
    .open_o  (win_open_o)
  );

  assign cnt_en = win_open_o && !sleep_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic       hit;
    logic [1:0] step;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_q[g] <= EV_NONE;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g + 1)) sel_q[g] <= wr_data_i[SEL_W-1:0];
    end

    always_comb begin
      hit = 1'b0;
      for (int e = 0; e < NUM_EVT; e++)
        if (sel_q[g] == SEL_W'(e + 1)) hit = evt_i[e];
    end

    assign assigned[g] = (sel_q[g] != EV_NONE) && (int'(sel_q[g]) <= NUM_EVT);
    assign step = !hit ? 2'd0 : (sel_q[g] == EV_BRANCH) ? 2'd2 : 2'd1;

    perf_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_cmd),
      .en_i   (cnt_en),
      .step_i (step),
      .cnt_o  (cnt[g]),
      .ovf_o  (ovf[g])
    );

    a_r6_sleep_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_i && !clr_cmd) |=> $stable(cnt[g]));
  end

  assign gated      = (mode_q == MODE_C1C2) || (mode_q == MODE_C2C1);
  assign brk_mask_o = gated ? 2'b11 : 2'b00;
  assign cfg_err_o  = gated && (assigned == '0);
  assign rd_cnt_o   = cnt[rd_ch_i];
  assign rd_valid_o = !ovf[rd_ch_i];

  // R10: nothing assigned means nothing can move
  a_r10_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !wr_en_i) |=> $stable(cnt[0]));
endmodule

// File: tb/test_perf_counter_unit.sv
module test_perf_counter_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic [5:0] evt = 0;
  logic c1 = 0, c2 = 0, run = 0, slp = 0, wen = 0;
  logic [2:0] waddr = 0;
  logic [7:0] wdata = 0;
  logic [1:0] rch = 0;
  logic [CW-1:0] rcnt;
  logic rvalid, cerr, wopen;
  logic [1:0] bmask;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_unit #(.CNT_W(CW)) i_perf_counter_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cond1_i(c1), .cond2_i(c2),
    .run_i(run), .sleep_i(slp), .wr_en_i(wen), .wr_addr_i(waddr),
    .wr_data_i(wdata), .rd_ch_i(rch), .rd_cnt_o(rcnt), .rd_valid_o(rvalid),
    .cfg_err_o(cerr), .win_open_o(wopen), .brk_mask_o(bmask));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(int ch, string req, int exp_cnt, int exp_valid);
    rch = 2'(ch);
    #1;
    chk(req, int'(rcnt), exp_cnt);
    chk(req, int'(rvalid), exp_valid);
  endtask

  task automatic wr(int a, int d);
    waddr = 3'(a); wdata = 8'(d); wen = 1;
    @(negedge clk);
    wen = 0;
  endtask

  task automatic cyc(logic [5:0] e, logic k1, logic k2);
    evt = e; c1 = k1; c2 = k2;
    @(negedge clk);
    evt = 0; c1 = 0; c2 = 0;
  endtask

  task automatic t_reset;
    for (int ch = 0; ch < 4; ch++) rd(ch, "R1", 0, 1);
    chk("R1 cfg_err", int'(cerr), 0);
    chk("R1 mask", int'(bmask), 0);
  endtask

  task automatic t_run_multi;
    wr(0, 0); wr(1, 1); wr(2, 3); wr(3, 4); wr(4, 6); wr(5, 0);
    run = 1;
    cyc(6'b100101, 0, 0);
    cyc(6'b000001, 0, 0);
    cyc(6'b100101, 0, 0);
    cyc(6'b001001, 0, 0);
    cyc(6'b000101, 0, 0);
    run = 0;
    cyc(6'b111111, 0, 0);
    cyc(6'b111111, 0, 0);
    rd(0, "R2 cycles", 5, 1);
    rd(1, "R11 instr", 3, 1);
    rd(2, "R11 irq", 1, 1);
    rd(3, "R11 stall", 2, 1);
    chk("R9 run mask", int'(bmask), 0);
  endtask

  task automatic t_branch;
    wr(1, 2); wr(5, 0);
    run = 1;
    cyc(6'b000010, 0, 0);
    cyc(6'b000000, 0, 0);
    cyc(6'b000010, 0, 0);
    cyc(6'b000010, 0, 0);
    run = 0;
    rd(0, "R3 branch x2", 6, 1);
  endtask

  task automatic t_c1c2;
    wr(1, 1); wr(2, 3); wr(0, 1); wr(5, 0);
    chk("R9 gated mask", int'(bmask), 3);
    run = 1;
    cyc(6'b000001, 0, 0);
    cyc(6'b000001, 0, 1);   // stop with no window: ignored
    cyc(6'b000101, 1, 0);   // start counted
    cyc(6'b000001, 0, 0);
    cyc(6'b000001, 0, 0);
    cyc(6'b000101, 0, 1);   // stop counted
    cyc(6'b000101, 0, 0);
    cyc(6'b000101, 1, 0);   // no reopen
    cyc(6'b000101, 0, 0);
    run = 0;
    rd(0, "R4 cycles", 4, 1);
    rd(1, "R4 instr", 2, 1);
  endtask

  task automatic t_c2c1;
    wr(0, 2); wr(5, 0);
    cyc(6'b000001, 1, 0);   // wrong order: ignored
    cyc(6'b000001, 0, 1);   // start
    cyc(6'b000001, 0, 0);
    cyc(6'b000001, 1, 0);   // stop
    cyc(6'b000001, 0, 0);
    rd(0, "R5 cycles", 3, 1);
  endtask

  task automatic t_sleep;
    wr(0, 0); wr(5, 0);
    run = 1;
    cyc(6'b000001, 0, 0);
    slp = 1;
    cyc(6'b000001, 0, 0);
    cyc(6'b000001, 0, 0);
    slp = 0;
    cyc(6'b000001, 0, 0);
    run = 0;
    rd(0, "R6 sleep pause", 2, 1);
  endtask

  task automatic t_overflow;
    wr(1, 2); wr(5, 0);
    run = 1;
    for (int i = 0; i < 127; i++) cyc(6'b000010, 0, 0);
    rd(0, "R7 below limit", 254, 1);
    cyc(6'b000010, 0, 0);
    rd(0, "R7 overflow", 254, 0);
    cyc(6'b000010, 0, 0);
    cyc(6'b000010, 0, 0);
    rd(0, "R7 sticky", 254, 0);
    run = 0;
    wr(5, 0);
    rd(0, "R8 init clears ovf", 0, 1);
  endtask

  task automatic t_clear_same_cycle;
    wr(1, 1); wr(5, 0);
    run = 1;
    cyc(6'b000001, 0, 0);
    cyc(6'b000001, 0, 0);
    evt = 6'b000001;
    wr(5, 0);
    rd(0, "R8 clear wins", 0, 1);
    cyc(6'b000001, 0, 0);
    run = 0;
    rd(0, "R8 counts after", 1, 1);
  endtask

  task automatic t_cfg_err;
    wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 7);
    wr(0, 1);
    #1 chk("R10 err mode1", int'(cerr), 1);
    wr(0, 0);
    #1 chk("R10 no err run", int'(cerr), 0);
    wr(0, 2); wr(3, 5);
    #1 chk("R10 cleared by assign", int'(cerr), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run_multi();
    t_branch();
    t_c1c2();
    t_c2c1();
    t_sleep();
    t_overflow();
    t_clear_same_cycle();
    t_cfg_err();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule